// File: doc/BRIEF.md
# SIMD Vector Permute Unit

This block executes the unzip, transpose and interleave family of SIMD permutes. It receives a 32-bit instruction word and two 128-bit source vectors, called the first and the second source. From the instruction word it takes the permute kind, the variant bit, the element size and the vector width. It then produces a 128-bit destination value in which every element is copied from one of the two sources. The result goes out together with the destination register index taken from the same word.

Each 8-bit lane of the result has its own source mapping. That mapping picks the source vector and the source byte from the permute kind, the variant, the element size and the vector width. The outputs are registered: one cycle after an accepted strobe the block shows either a valid result or an illegal-encoding flag. Lane 0 is always the least significant byte of each vector. Element indices address the full 128-bit source registers.

Top module: `vperm_unit`

## Requirements
- R1: While reset is held and in the cycle after it, out_valid and out_illegal are low and out_result and out_rd are zero.
- R2: A legal word accepted with in_valid high gives out_valid high on the following clock edge only, with out_rd equal to instr[4:0].
- R3: A word is illegal when instr[13:12] is 0, or when instr[23:22] is 3 and instr[30] is 0. It then gives out_illegal high one cycle later, with out_valid low and out_result zero.
- R4: Unzip (instr[13:12] = 1) with element count E and half H = E/2: result element i takes first-source element 2i+p when i < H, and otherwise second-source element 2(i−H)+p. Here p is instr[14].
- R5: Transpose (instr[13:12] = 2): result element i takes element (i with bit 0 cleared)+p. That element comes from the second source when i is odd and from the first source when i is even.
- R6: Interleave (instr[13:12] = 3): result element i takes element p·H + (i>>1). That element comes from the second source when i is odd and from the first source when i is even.
- R7: The element width is 8 << instr[23:22] bits, and the vector is 128 bits when instr[30] = 1 and 64 bits otherwise. Result element i sits at bit i × width, and with a 64-bit vector bits 127:64 of the result are zero.
- R8: A cycle with in_valid low gives out_valid and out_illegal low on the next edge and leaves out_result and out_rd unchanged.
- R9: The variant bit instr[14] changes only which source elements are chosen: variant 0 and variant 1 of the same word both produce a valid result, each following its own formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and sources are present |
| instr | input | 32 | Instruction word |
| vec_n | input | 128 | First source vector |
| vec_m | input | 128 | Second source vector |
| out_valid | output | 1 | Registered result is valid |
| out_rd | output | 5 | Destination register index |
| out_result | output | 128 | Permuted result |
| out_illegal | output | 1 | Accepted word was an illegal encoding |

## Verification
A wrong lane mapping shows up as a wrong byte in out_result one cycle after the strobe. The misplaced byte lands in the lane whose mapping is broken, and it appears only for the size, width and kind combinations that use that mapping. For that reason every kind, variant, size and width combination is run against random sources. A decode fault instead shows in that same cycle as a swapped out_valid or out_illegal, or as stray bits above bit 63 for a 64-bit operation. A fault in the hold logic shows in the first idle cycle as a changed result or rd.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int unsigned VEC_W      = 128;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned NUM_LANES  = VEC_W / LANE_W;
    localparam int unsigned LANE_IDX_W = $clog2(NUM_LANES);
    localparam int unsigned REG_IDX_W  = 5;
    localparam int unsigned INSTR_W    = 32;

    typedef enum logic [1:0] {
        OP_BAD   = 2'd0,
        OP_UNZIP = 2'd1,
        OP_TRANS = 2'd2,
        OP_ZIP   = 2'd3
    } perm_op_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] rd;
        perm_op_e             op;
        logic                 part;
        logic [1:0]           sz;
        logic                 wide;
    } perm_ctl_t;

    typedef struct packed {
        logic                  live;
        logic                  from_m;
        logic [LANE_IDX_W-1:0] idx;
    } lane_src_t;

    // Source byte for one result lane
    function automatic lane_src_t lane_source(perm_ctl_t c, int unsigned lane);
        int unsigned i, w, n_el, mid, j, lanes;
        lane_src_t   r;
        lanes = c.wide ? NUM_LANES : NUM_LANES / 2;
        i     = lane >> c.sz;
        w     = lane & ((32'd1 << c.sz) - 32'd1);
        n_el  = lanes >> c.sz;
        mid   = n_el / 2;
        r.live   = (lane < lanes);
        r.from_m = 1'b0;
        j        = 0;
        case (c.op)
            OP_UNZIP: begin
                if (i < mid) begin
                    j = 2 * i + 32'(c.part);
                end else begin
                    j = 2 * (i - mid) + 32'(c.part);
                    r.from_m = 1'b1;
                end
            end
            OP_TRANS: begin
                j = (i & ~32'd1) + 32'(c.part);
                r.from_m = ((i % 2) == 1);
            end
            OP_ZIP: begin
                j = (c.part ? mid : 32'd0) + i / 2;
                r.from_m = ((i % 2) == 1);
            end
            default: r.live = 1'b0;
        endcase
        r.idx = LANE_IDX_W'((j << c.sz) | w);
        return r;
    endfunction

endpackage

// File: rtl/vperm_decode.sv
module vperm_decode
    import vperm_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output perm_ctl_t          ctl,
    output logic               illegal
);
    always_comb begin
        ctl.rd   = instr[4:0];
        ctl.op   = perm_op_e'(instr[13:12]);
        ctl.part = instr[14];
        ctl.sz   = instr[23:22];
        ctl.wide = instr[30];
        illegal  = (ctl.op == OP_BAD) || (ctl.sz == 2'd3 && !ctl.wide);
    end
endmodule

// File: rtl/vperm_lane_map.sv
module vperm_lane_map
    import vperm_pkg::*;
#(
    parameter int unsigned LANE = 0
) (
    input  perm_ctl_t          ctl,
    input  logic [VEC_W-1:0]   vec_n,
    input  logic [VEC_W-1:0]   vec_m,
    output logic [LANE_W-1:0]  lane_out
);
    lane_src_t src;

    always_comb begin
        src = lane_source(ctl, LANE);
        if (!src.live)
            lane_out = '0;
        else if (src.from_m)
            lane_out = vec_m[src.idx*LANE_W +: LANE_W];
        else
            lane_out = vec_n[src.idx*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [31:0]          instr,
    input  logic [127:0]         vec_n,
    input  logic [127:0]         vec_m,
    output logic                 out_valid,
    output logic [4:0]           out_rd,
    output logic [127:0]         out_result,
    output logic                 out_illegal
);
    perm_ctl_t          ctl;
    logic               illegal;
    logic [VEC_W-1:0]   perm_res;

    vperm_decode u_decode (
        .instr   (instr),
        .ctl     (ctl),
        .illegal (illegal)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        vperm_lane_map #(.LANE(g)) u_lane (
            .ctl      (ctl),
            .vec_n    (vec_n),
            .vec_m    (vec_m),
            .lane_out (perm_res[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid && !illegal;
            out_illegal <= in_valid && illegal;
            if (in_valid) begin
                out_rd     <= ctl.rd;
                out_result <= illegal ? '0 : perm_res;
            end
        end
    end

    AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal)); // R3
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0)); // R3
    AST_LEGAL_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !illegal) |=> (out_valid && out_rd == $past(instr[4:0]))); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_result) && $stable(out_rd))); // R8
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !illegal && !instr[30]) |=> (out_result[127:64] == 64'd0)); // R7
endmodule

// File: tb/test_vperm_unit.sv
module test_vperm_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic [127:0] vec_n, vec_m;
    logic         out_valid, out_illegal;
    logic [4:0]   out_rd;
    logic [127:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    vperm_unit i_vperm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .vec_n(vec_n), .vec_m(vec_m), .out_valid(out_valid),
        .out_rd(out_rd), .out_result(out_result), .out_illegal(out_illegal)
    );

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int op, int part, int sz, int q, int rd);
        logic [31:0] w = '0;
        w[4:0]   = 5'(rd);
        w[9:5]   = 5'd3;
        w[20:16] = 5'd7;
        w[13:12] = 2'(op);
        w[14]    = 1'(part);
        w[23:22] = 2'(sz);
        w[30]    = 1'(q);
        return w;
    endfunction

    function automatic logic [127:0] model(int op, int part, int sz, int q,
                                           logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        int esz   = 8 << sz;
        int elems = (q ? 128 : 64) / esz;
        int half  = elems / 2;
        for (int i = 0; i < elems; i++) begin
            int j;
            bit use_b;
            if (op == 1) begin
                use_b = (i >= half);
                j = use_b ? 2 * (i - half) + part : 2 * i + part;
            end else if (op == 2) begin
                use_b = (i % 2 == 1);
                j = (i / 2) * 2 + part;
            end else begin
                use_b = (i % 2 == 1);
                j = part * half + i / 2;
            end
            for (int k = 0; k < esz; k++)
                r[i*esz + k] = use_b ? b[j*esz + k] : a[j*esz + k];
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic issue(logic [31:0] w);
        @(negedge clk);
        instr = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b0; instr = '0; vec_n = '1; vec_m = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", 128'(out_valid), 128'd0);
        check("R1 illegal", 128'(out_illegal), 128'd0);
        check("R1 result", out_result, 128'd0);
        check("R1 rd", 128'(out_rd), 128'd0);
    endtask

    task automatic test_all_combos();
        for (int op = 1; op <= 3; op++)
            for (int part = 0; part < 2; part++)
                for (int sz = 0; sz < 4; sz++)
                    for (int q = 0; q < 2; q++) begin
                        if (sz == 3 && q == 0) continue;
                        for (int rep = 0; rep < 3; rep++) begin
                            logic [127:0] exp;
                            string tag;
                            vec_n = rnd128(); vec_m = rnd128();
                            exp = model(op, part, sz, q, vec_n, vec_m);
                            issue(mk(op, part, sz, q, (op * 8 + sz + rep) % 32));
                            tag = (op == 1) ? "R4 unzip" : (op == 2) ? "R5 transpose" : "R6 interleave";
                            check(tag, out_result, exp);
                            check("R2 valid", 128'(out_valid), 128'd1);
                            check("R2 rd", 128'(out_rd), 128'((op * 8 + sz + rep) % 32));
                            if (q == 0)
                                check("R7 upper zero", 128'(out_result[127:64]), 128'd0);
                        end
                    end
    endtask

    task automatic test_layout();
        // R7: 8-bit interleave, 128-bit: bytes alternate n0,m0,n1,m1... from LSB
        vec_n = 128'h0f0e0d0c0b0a09080706050403020100;
        vec_m = 128'h1f1e1d1c1b1a19181716151413121110;
        issue(mk(3, 0, 0, 1, 2));
        check("R7 lsb layout", out_result, 128'h17071606150514041303120211011000);
        // R9: same word with variant 1 takes upper halves
        issue(mk(3, 1, 0, 1, 2));
        check("R9 variant", out_result, 128'h1f0f1e0e1d0d1c0c1b0b1a0a19091808);
        check("R9 valid", 128'(out_valid), 128'd1);
    endtask

    task automatic test_illegal();
        vec_n = rnd128(); vec_m = rnd128();
        issue(mk(0, 0, 1, 1, 4));
        check("R3 op0 flag", 128'(out_illegal), 128'd1);
        check("R3 op0 valid", 128'(out_valid), 128'd0);
        check("R3 op0 result", out_result, 128'd0);
        issue(mk(2, 1, 3, 0, 5));
        check("R3 sz3 narrow flag", 128'(out_illegal), 128'd1);
        check("R3 sz3 narrow valid", 128'(out_valid), 128'd0);
        check("R3 sz3 narrow result", out_result, 128'd0);
    endtask

    task automatic test_idle_hold();
        logic [127:0] exp;
        vec_n = rnd128(); vec_m = rnd128();
        exp = model(1, 0, 2, 1, vec_n, vec_m);
        issue(mk(1, 0, 2, 1, 9));
        check("R4 before idle", out_result, exp);
        instr = mk(0, 0, 0, 0, 1); vec_n = rnd128(); vec_m = rnd128();
        repeat (2) @(negedge clk);
        check("R8 valid low", 128'(out_valid), 128'd0);
        check("R8 illegal low", 128'(out_illegal), 128'd0);
        check("R8 result held", out_result, exp);
        check("R8 rd held", 128'(out_rd), 128'd9);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_all_combos();
                test_layout();
                test_illegal();
                test_idle_hold();
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule